// File: doc/BRIEF.md
# Virtual Machine Identifier Controller

This block keeps track of which virtual machine is running on a processor that supports nested virtual machines. The running machine is named by a path of short syllables, one per nesting level. The empty path stands for the bare machine at level 0. The path is held inside the block and has no read or write port. Only two commands change it. An append command pushes one syllable and enters a child machine. A fault command pops the path back to the level of the monitor that has to handle the fault.

Each machine has a small control block held in internal storage. It records which child the machine last entered (its next-syllable link) and the instruction counter and relocation-bounds value saved when the machine was last suspended. On an append, the block first stores the operand in the current machine's link. If the entered child had itself been running a deeper machine when it was interrupted, the block follows the stored links, one level per cycle, until it reaches a machine with an empty link. Every level entered produces a register-load pulse carrying that machine's saved context. A fault saves the faulting machine's context, then sends the monitor to a fixed handler address together with the monitor's own saved relocation-bounds value.

A control block is keyed by the machine's level and the last syllable of its path. Syllable value 0 means "no syllable".

Top module: `vmid_ctrl`

## Requirements
- R1: After reset the level is 0 and `busy`, `ld_valid` and `cap_exc` are low. Every control block starts with a null link and a zero instruction counter and relocation-bounds value.
- R2: The level rises only in the cycle after an accepted append or a chain step. It falls only in the cycle after a fault command. No port reads or writes the syllable path.
- R3: When the block is idle, an accepted append raises the level by one. In the next cycle it gives one `ld_valid` pulse, with `ld_ic`/`ld_rb` set to the saved context of the machine just entered (zero if that machine was never suspended).
- R4: An accepted append writes its operand syllable into the link of the machine that issued it. A later append that enters that machine therefore resumes the linked child.
- R5: If the entered machine's link is non-null, the block enters the linked machine in each following cycle. It holds `busy` high while a further step is pending, and gives one load pulse per level entered, shallowest first.
- R6: An append made while `cap_recurse` is low, or with operand syllable 0, gives a one-cycle `cap_exc` pulse in the next cycle. It leaves the level unchanged and produces no load pulse.
- R7: A fault command whose target level is below the current level stores `cur_ic`/`cur_rb` into the faulting machine's control block. The level equals the target in the next cycle.
- R8: After a fault the block gives one load pulse with `ld_ic` equal to `HANDLER_IC` (1) and `ld_rb` equal to the relocation-bounds value saved in the monitor's control block.
- R9: A fault command whose target level is not below the current level is ignored: no level change, no load pulse and no context saved.
- R10: An append made when the level already equals `DEPTH` (4) raises `cap_exc` instead of entering a deeper machine, and the level stays at `DEPTH`.
- R11: A fault command takes priority over an append in the same cycle. Both commands are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| append_req | input | 1 | Append command, one cycle |
| append_syl | input | SYL_W | Syllable to append |
| cap_recurse | input | 1 | Current machine may host virtual machines |
| fault_req | input | 1 | VM-fault command, one cycle |
| fault_lvl | input | LVL_W | Level of the monitor that takes the fault |
| cur_ic | input | REG_W | Running instruction counter, saved on a fault |
| cur_rb | input | REG_W | Running relocation-bounds value, saved on a fault |
| busy | output | 1 | Resume chain still in progress |
| level | output | LVL_W | Current nesting level |
| cap_exc | output | 1 | Capability exception pulse |
| ld_valid | output | 1 | Register-load pulse |
| ld_ic | output | REG_W | Instruction counter to load |
| ld_rb | output | REG_W | Relocation-bounds value to load |

## Verification
The bound checker checks, on every cycle, the rules that can be seen from the ports at once. The level stays within `DEPTH`, moves by one step per append or chain cycle, and falls only after a fault command. Every fall comes with a handler-address load. An exception pulse never moves the level. The content of the hidden control blocks can only be shown by the bench's scenarios. These cover context saved by one fault and returned by a later resume chain, links written by one append and followed by another, and the monitor's own relocation-bounds value returned on a fault. The scoreboard matches every load and exception pulse in order.

// File: rtl/vmid_pkg.sv
package vmid_pkg;

    localparam int VMID_DEPTH_DEF = 4;
    localparam int VMID_SYL_W_DEF = 4;
    localparam int VMID_REG_W_DEF = 16;
    localparam int VMID_HANDLER_DEF = 1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CHAIN = 1'b1
    } vmid_state_e;

endpackage

// File: rtl/vmid_cb_store.sv
module vmid_cb_store #(
    parameter int LVL_W = 3,
    parameter int SYL_W = 4,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] ra_lvl,
    input  logic [SYL_W-1:0] ra_syl,
    output logic [SYL_W-1:0] ra_link,
    output logic [REG_W-1:0] ra_ic,
    output logic [REG_W-1:0] ra_rb,
    input  logic [LVL_W-1:0] rb_lvl,
    input  logic [SYL_W-1:0] rb_syl,
    output logic [REG_W-1:0] rb_rb,
    input  logic             lnk_we,
    input  logic [LVL_W-1:0] lnk_lvl,
    input  logic [SYL_W-1:0] lnk_syl,
    input  logic [SYL_W-1:0] lnk_val,
    input  logic             ctx_we,
    input  logic [LVL_W-1:0] ctx_lvl,
    input  logic [SYL_W-1:0] ctx_syl,
    input  logic [REG_W-1:0] ctx_ic,
    input  logic [REG_W-1:0] ctx_rb
);
    localparam int IDX_W   = LVL_W + SYL_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [SYL_W-1:0] link_mem [ENTRIES];
    logic [REG_W-1:0] ic_mem   [ENTRIES];
    logic [REG_W-1:0] rb_mem   [ENTRIES];

    logic [IDX_W-1:0] a_idx, b_idx, l_idx, c_idx;

    assign a_idx = {ra_lvl, ra_syl};
    assign b_idx = {rb_lvl, rb_syl};
    assign l_idx = {lnk_lvl, lnk_syl};
    assign c_idx = {ctx_lvl, ctx_syl};

    assign ra_link = link_mem[a_idx];
    assign ra_ic   = ic_mem[a_idx];
    assign ra_rb   = rb_mem[a_idx];
    assign rb_rb   = rb_mem[b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) link_mem[i] <= '0;
        end else if (lnk_we) begin
            link_mem[l_idx] <= lnk_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ic_mem[i] <= '0;
                rb_mem[i] <= '0;
            end
        end else if (ctx_we) begin
            ic_mem[c_idx] <= ctx_ic;
            rb_mem[c_idx] <= ctx_rb;
        end
    end

endmodule

// File: rtl/vmid_path.sv
module vmid_path #(
    parameter int DEPTH = 4,
    parameter int LVL_W = 3,
    parameter int SYL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [SYL_W-1:0] push_syl,
    input  logic             trunc,
    input  logic [LVL_W-1:0] trunc_lvl,
    input  logic [LVL_W-1:0] probe_lvl,
    output logic [SYL_W-1:0] probe_syl,
    output logic [SYL_W-1:0] top_syl,
    output logic [LVL_W-1:0] level
);
    logic [SYL_W-1:0] syl_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            for (int i = 0; i < DEPTH; i++) syl_q[i] <= '0;
        end else if (trunc) begin
            level <= trunc_lvl;
        end else if (push) begin
            level <= level + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (level == LVL_W'(i)) syl_q[i] <= push_syl;
            end
        end
    end

    always_comb begin
        probe_syl = '0;
        top_syl   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (probe_lvl == LVL_W'(i + 1)) probe_syl = syl_q[i];
            if (level == LVL_W'(i + 1))     top_syl   = syl_q[i];
        end
    end

endmodule

// File: rtl/vmid_ctrl.sv
module vmid_ctrl
    import vmid_pkg::*;
#(
    parameter int DEPTH      = VMID_DEPTH_DEF,
    parameter int SYL_W      = VMID_SYL_W_DEF,
    parameter int REG_W      = VMID_REG_W_DEF,
    parameter int HANDLER_IC = VMID_HANDLER_DEF,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             append_req,
    input  logic [SYL_W-1:0] append_syl,
    input  logic             cap_recurse,
    input  logic             fault_req,
    input  logic [LVL_W-1:0] fault_lvl,
    input  logic [REG_W-1:0] cur_ic,
    input  logic [REG_W-1:0] cur_rb,
    output logic             busy,
    output logic [LVL_W-1:0] level,
    output logic             cap_exc,
    output logic             ld_valid,
    output logic [REG_W-1:0] ld_ic,
    output logic [REG_W-1:0] ld_rb
);
    vmid_state_e      state_q;
    logic [SYL_W-1:0] pend_q;

    logic             idle, do_fault, app_req, app_ok, step;
    logic [SYL_W-1:0] step_syl, cur_syl, mon_syl;
    logic [LVL_W-1:0] next_lvl;
    logic [SYL_W-1:0] new_link;
    logic [REG_W-1:0] new_ic, new_rb, mon_rb;

    assign idle     = (state_q == ST_IDLE);
    assign do_fault = idle && fault_req && (fault_lvl < level);
    assign app_req  = idle && append_req && !do_fault;
    assign app_ok   = app_req && cap_recurse && (level < LVL_W'(DEPTH))
                      && (append_syl != '0);
    assign step     = app_ok || (state_q == ST_CHAIN);
    assign step_syl = (state_q == ST_CHAIN) ? pend_q : append_syl;
    assign next_lvl = level + 1'b1;
    assign busy     = (state_q == ST_CHAIN);

    vmid_path #(
        .DEPTH(DEPTH), .LVL_W(LVL_W), .SYL_W(SYL_W)
    ) u_path (
        .clk       (clk),
        .rst       (rst),
        .push      (step),
        .push_syl  (step_syl),
        .trunc     (do_fault),
        .trunc_lvl (fault_lvl),
        .probe_lvl (fault_lvl),
        .probe_syl (mon_syl),
        .top_syl   (cur_syl),
        .level     (level)
    );

    vmid_cb_store #(
        .LVL_W(LVL_W), .SYL_W(SYL_W), .REG_W(REG_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_lvl  (next_lvl),
        .ra_syl  (step_syl),
        .ra_link (new_link),
        .ra_ic   (new_ic),
        .ra_rb   (new_rb),
        .rb_lvl  (fault_lvl),
        .rb_syl  (mon_syl),
        .rb_rb   (mon_rb),
        .lnk_we  (step),
        .lnk_lvl (level),
        .lnk_syl (cur_syl),
        .lnk_val (step_syl),
        .ctx_we  (do_fault),
        .ctx_lvl (level),
        .ctx_syl (cur_syl),
        .ctx_ic  (cur_ic),
        .ctx_rb  (cur_rb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            cap_exc  <= 1'b0;
            ld_valid <= 1'b0;
            ld_ic    <= '0;
            ld_rb    <= '0;
        end else begin
            cap_exc  <= app_req && !app_ok;
            ld_valid <= step || do_fault;
            if (step) begin
                pend_q  <= new_link;
                ld_ic   <= new_ic;
                ld_rb   <= new_rb;
                state_q <= ((new_link != '0) && (next_lvl < LVL_W'(DEPTH)))
                           ? ST_CHAIN : ST_IDLE;
            end else if (do_fault) begin
                ld_ic <= REG_W'(HANDLER_IC);
                ld_rb <= mon_rb;
            end
        end
    end

endmodule

// File: rtl/vmid_ctrl_chk.sv
module vmid_ctrl_chk #(
    parameter int DEPTH      = 4,
    parameter int LVL_W      = 3,
    parameter int REG_W      = 16,
    parameter int HANDLER_IC = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             append_req,
    input logic             fault_req,
    input logic             busy,
    input logic [LVL_W-1:0] level,
    input logic             cap_exc,
    input logic             ld_valid,
    input logic [REG_W-1:0] ld_ic
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level == '0) && !busy && !ld_valid && !cap_exc);

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R2
    rise_source_chk: assert property (@(posedge clk) disable iff (rst)
        (level > $past(level)) |-> ($past(append_req) || $past(busy)));

    // R2
    fall_source_chk: assert property (@(posedge clk) disable iff (rst)
        (level < $past(level)) |-> $past(fault_req));

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (level > $past(level)) |-> (level == $past(level) + 1'b1) && ld_valid);

    // R5
    chain_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (level == $past(level) + 1'b1));

    // R6
    exc_level_chk: assert property (@(posedge clk) disable iff (rst)
        cap_exc |-> $stable(level) && !ld_valid);

    // R8
    handler_load_chk: assert property (@(posedge clk) disable iff (rst)
        (level < $past(level)) |-> ld_valid && (ld_ic == REG_W'(HANDLER_IC)));

endmodule

bind vmid_ctrl vmid_ctrl_chk #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .REG_W(REG_W), .HANDLER_IC(HANDLER_IC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .append_req (append_req),
    .fault_req  (fault_req),
    .busy       (busy),
    .level      (level),
    .cap_exc    (cap_exc),
    .ld_valid   (ld_valid),
    .ld_ic      (ld_ic)
);

// File: tb/tb_vmid_ctrl.sv
module tb_vmid_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SYL_W = 4;
    localparam int REG_W = 16;
    localparam int LVL_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             append_req = 1'b0;
    logic [SYL_W-1:0] append_syl = '0;
    logic             cap_recurse = 1'b1;
    logic             fault_req = 1'b0;
    logic [LVL_W-1:0] fault_lvl = '0;
    logic [REG_W-1:0] cur_ic = '0;
    logic [REG_W-1:0] cur_rb = '0;
    logic             busy, cap_exc, ld_valid;
    logic [LVL_W-1:0] level;
    logic [REG_W-1:0] ld_ic, ld_rb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected item: {is_exc, ic, rb}
    logic [2*REG_W:0] exp_q [$];
    string            tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vmid_ctrl dut (
        .clk(clk), .rst(rst),
        .append_req(append_req), .append_syl(append_syl),
        .cap_recurse(cap_recurse),
        .fault_req(fault_req), .fault_lvl(fault_lvl),
        .cur_ic(cur_ic), .cur_rb(cur_rb),
        .busy(busy), .level(level), .cap_exc(cap_exc),
        .ld_valid(ld_valid), .ld_ic(ld_ic), .ld_rb(ld_rb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic exp_load(input logic [REG_W-1:0] ic, input logic [REG_W-1:0] rb,
                            input string tag);
        exp_q.push_back({1'b0, ic, rb});
        tag_q.push_back(tag);
    endtask

    task automatic exp_exc(input string tag);
        exp_q.push_back({1'b1, {REG_W{1'b0}}, {REG_W{1'b0}}});
        tag_q.push_back(tag);
    endtask

    // monitor: compare every pulse against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && (ld_valid || cap_exc)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected pulse", {15'd0, cap_exc, ld_ic}, 0);
            end else begin
                logic [2*REG_W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cap_exc == e[2*REG_W] && ld_valid == !e[2*REG_W], {t, " kind"},
                    int'(cap_exc), int'(e[2*REG_W]));
                if (!e[2*REG_W]) begin
                    chk(ld_ic == e[2*REG_W-1:REG_W], {t, " ic"}, ld_ic, e[2*REG_W-1:REG_W]);
                    chk(ld_rb == e[REG_W-1:0], {t, " rb"}, ld_rb, e[REG_W-1:0]);
                end
            end
        end
    end

    task automatic do_append(input logic [SYL_W-1:0] s, input bit cap);
        @(negedge clk);
        append_req = 1'b1; append_syl = s; cap_recurse = cap;
        @(negedge clk);
        append_req = 1'b0; cap_recurse = 1'b1;
    endtask

    task automatic do_fault(input logic [LVL_W-1:0] t, input logic [REG_W-1:0] ic,
                            input logic [REG_W-1:0] rb);
        @(negedge clk);
        fault_req = 1'b1; fault_lvl = t; cur_ic = ic; cur_rb = rb;
        @(negedge clk);
        fault_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(level == 0, "R1 level", level, 0);
        chk(!busy && !ld_valid && !cap_exc, "R1 idle outputs", {busy, ld_valid, cap_exc}, 0);

        // R3 enter fresh machines
        exp_load(16'h0, 16'h0, "R3 enter 1.3");
        do_append(4'd3, 1'b1);
        chk(level == 1, "R3 level after append", level, 1);
        exp_load(16'h0, 16'h0, "R3 enter 2.5");
        do_append(4'd5, 1'b1);
        chk(level == 2, "R3 level", level, 2);

        // R7 R8 fault to real machine
        exp_load(16'h1, 16'h0, "R8 handler from 2");
        do_fault(3'd0, 16'h1234, 16'h00AB);
        chk(level == 0, "R7 level after fault", level, 0);

        // R5 R4 resume chain through stored link
        exp_load(16'h0, 16'h0, "R5 chain step 1");
        exp_load(16'h1234, 16'h00AB, "R5 chain step 2");
        do_append(4'd3, 1'b1);
        chk(busy == 1'b1, "R5 busy mid chain", busy, 1);
        chk(level == 1, "R5 level mid chain", level, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R5 busy end", busy, 0);
        chk(level == 2, "R4 level after resume", level, 2);

        // R6 capability and null syllable
        exp_exc("R6 no capability");
        do_append(4'd7, 1'b0);
        chk(level == 2, "R6 level held", level, 2);
        exp_exc("R6 null syllable");
        do_append(4'd0, 1'b1);
        chk(level == 2, "R6 level held null", level, 2);

        // R11 fault wins over append in the same cycle
        exp_load(16'h1, 16'h0, "R11 fault priority");
        @(negedge clk);
        append_req = 1'b1; append_syl = 4'd9;
        fault_req = 1'b1; fault_lvl = 3'd1; cur_ic = 16'h2222; cur_rb = 16'h0CC0;
        @(negedge clk);
        append_req = 1'b0; fault_req = 1'b0;
        chk(level == 1, "R11 level", level, 1);

        exp_load(16'h1, 16'h0, "R8 handler from 1");
        do_fault(3'd0, 16'h3333, 16'h0D0D);
        chk(level == 0, "R7 level to 0", level, 0);

        // chain restores both saved contexts
        exp_load(16'h3333, 16'h0D0D, "R5 resume 1.3");
        exp_load(16'h2222, 16'h0CC0, "R5 resume 2.5");
        do_append(4'd3, 1'b1);
        wait_idle();
        chk(level == 2, "R5 level after chain", level, 2);

        // R8 monitor relocation-bounds restored
        exp_load(16'h1, 16'h0D0D, "R8 monitor rb");
        do_fault(3'd1, 16'h4444, 16'h0EE0);
        chk(level == 1, "R7 level to 1", level, 1);

        // R9 ignored faults
        do_fault(3'd1, 16'h5555, 16'h0FF0);
        chk(level == 1, "R9 equal target ignored", level, 1);
        do_fault(3'd3, 16'h5555, 16'h0FF0);
        chk(level == 1, "R9 deeper target ignored", level, 1);
        exp_load(16'h4444, 16'h0EE0, "R9 context not overwritten");
        do_append(4'd5, 1'b1);
        chk(level == 2, "R4 level", level, 2);

        // R10 depth limit
        exp_load(16'h0, 16'h0, "R10 enter 3.6");
        do_append(4'd6, 1'b1);
        exp_load(16'h0, 16'h0, "R10 enter 4.7");
        do_append(4'd7, 1'b1);
        chk(level == 4, "R10 level max", level, 4);
        exp_exc("R10 depth exception");
        do_append(4'd8, 1'b1);
        chk(level == 4, "R10 level held", level, 4);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule